// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block caches virtual-to-physical page translations for a small memory management unit. A requester presents a virtual address together with the access kind (read or write), its privilege (user or supervisor) and the number of the address space that is currently running. Every stored translation is compared against that request at once. On a match the physical address, a hit flag, the page's dirty state and its cacheability come back in the same cycle. If the page is supervisor-only and the request is from user level, a fault flag is raised instead.

On a miss the block captures the page number and address space number. It then requests a refill from an external table walker until the walker delivers the entry. The new translation goes into a slot chosen by a not-recently-used policy that is driven by per-entry accessed bits.

Because every entry is tagged with its address space number, a task switch only needs a new value on the address-space input. The stored translations can stay. For the cases where that is not wanted, there is a whole-buffer flush and a one-cycle invalidate of one address space.

Top module: `asn_xlate_buf`

## Requirements
- R1: After reset no entry is valid, `lk_hit`, `lk_fault` and `refill_req` are 0, and every lookup misses.
- R2: A lookup that matches a valid entry raises `lk_hit` combinationally in the same cycle. `lk_paddr` is then the stored 20-bit physical page number in bits 31:12 and `lk_vaddr[11:0]` in bits 11:0. `lk_paddr` is 0 whenever `lk_hit` is 0.
- R3: A lookup that matches nothing raises `refill_req` from the next cycle on, with `refill_vpn`/`refill_asn` holding the missed page number and address space. It stays up until the cycle in which `fill_valid` is high. The filled translation then hits on the following cycle.
- R4: A non-global entry matches only when its stored tag equals `cur_asn`. An entry installed with `fill_global`=1 matches under any `cur_asn`.
- R5: A matching lookup with `lk_user`=1 on an entry stored with user permission 0 gives `lk_fault`=1, `lk_hit`=0 and `lk_paddr`=0. A supervisor lookup (`lk_user`=0) of the same entry hits.
- R6: On a hit, `lk_dirty` shows the entry's dirty bit. The bit is 0 when the entry is installed and is set by any hit with `lk_write`=1, so later hits show 1.
- R7: A fill goes to the lowest-index invalid entry. If all entries are valid, it goes to the lowest-index entry whose accessed bit is 0. If every accessed bit is 1, all accessed bits are cleared and entry 0 is replaced. A filled entry starts with accessed 0, and every hit sets it to 1.
- R8: `flush_all` high for one cycle invalidates every entry, global ones included.
- R9: `inval_valid` high for one cycle invalidates every non-global entry whose tag equals `inval_asn`. Global entries and entries of other address spaces keep hitting.
- R10: On a hit, `lk_cacheable` returns the cacheability bit stored with the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 for a write access |
| lk_user | input | 1 | 1 for a user-level access, 0 for supervisor |
| cur_asn | input | 8 | Address space number of the running task |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Translation found but forbidden to a user access |
| lk_paddr | output | 32 | Translated physical address |
| lk_dirty | output | 1 | Dirty bit of the hit entry |
| lk_cacheable | output | 1 | Cacheability of the hit entry |
| refill_req | output | 1 | Refill request to the table walker |
| refill_vpn | output | 20 | Page number to be walked |
| refill_asn | output | 8 | Address space of the walk |
| fill_valid | input | 1 | Walker delivers an entry this cycle |
| fill_ppn | input | 20 | Physical page number from the walker |
| fill_global | input | 1 | Entry matches in every address space |
| fill_user_ok | input | 1 | Entry may be used by user accesses |
| fill_cacheable | input | 1 | Entry is cacheable |
| flush_all | input | 1 | Invalidate all entries |
| inval_valid | input | 1 | Invalidate one address space |
| inval_asn | input | 8 | Address space to invalidate |

## Verification
The assertions rely on three things the surrounding logic must guarantee. At most one stored entry may match any page number and address space. The walker answers only while a refill is outstanding. The requester keeps its lookup steady until the fill has landed. The bench keeps within the first rule because its page table decides the global flag from the page number alone, so a global translation is never installed next to a tagged copy of the same page. It keeps within the other two because it fills only in response to `refill_req` and holds the lookup inputs through each walk, with a randomized walk latency of a few cycles.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 32;
  localparam int OFS_W = 12;
  localparam int ASN_W = 8;
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;

  typedef struct packed {
    logic             valid;
    logic             glob;
    logic             accessed;
    logic             dirty;
    logic             user_ok;
    logic             cacheable;
    logic [ASN_W-1:0] asn;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } xent_t;
endpackage

// File: rtl/xlate_match.sv
module xlate_match
  import xlate_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  xent_t              ent [NUM_ENT],
  input  logic [VPN_W-1:0]   vpn,
  input  logic [ASN_W-1:0]   asn,
  output logic [NUM_ENT-1:0] match_v
);
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign match_v[i] = ent[i].valid && (ent[i].vpn == vpn) &&
                        (ent[i].glob || (ent[i].asn == asn));
  end
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter  int NUM_ENT = 16,
  localparam int IDX_W   = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] valid_v,
  input  logic [NUM_ENT-1:0] acc_v,
  output logic [IDX_W-1:0]   victim,
  output logic               age_wrap
);
  logic [NUM_ENT-1:0] free_v;
  logic [NUM_ENT-1:0] stale_v;

  assign free_v  = ~valid_v;
  assign stale_v = ~acc_v;

  always_comb begin
    victim   = '0;
    age_wrap = 1'b0;
    if (|free_v) begin
      for (int i = NUM_ENT - 1; i >= 0; i--) begin
        if (free_v[i]) victim = IDX_W'(i);
      end
    end else if (|stale_v) begin
      for (int i = NUM_ENT - 1; i >= 0; i--) begin
        if (stale_v[i]) victim = IDX_W'(i);
      end
    end else begin
      age_wrap = 1'b1;
    end
  end

  // R7
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|free_v) |-> !valid_v[victim]);

  // R7
  victim_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&valid_v) && !(&acc_v)) |-> !acc_v[victim]);
endmodule

// File: rtl/asn_xlate_buf.sv
module asn_xlate_buf
  import xlate_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_user,
  input  logic [ASN_W-1:0] cur_asn,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_dirty,
  output logic             lk_cacheable,
  output logic             refill_req,
  output logic [VPN_W-1:0] refill_vpn,
  output logic [ASN_W-1:0] refill_asn,
  input  logic             fill_valid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_global,
  input  logic             fill_user_ok,
  input  logic             fill_cacheable,
  input  logic             flush_all,
  input  logic             inval_valid,
  input  logic [ASN_W-1:0] inval_asn
);
  localparam int IDX_W = $clog2(NUM_ENT);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  xent_t              ent_q [NUM_ENT];
  xent_t              ent_d [NUM_ENT];
  logic               pend_q, pend_d;
  logic [VPN_W-1:0]   rvpn_q, rvpn_d;
  logic [ASN_W-1:0]   rasn_q, rasn_d;
  logic               ent_en, pend_en;

  logic [NUM_ENT-1:0] match_v, valid_v, acc_v;
  logic [IDX_W-1:0]   hit_idx, victim;
  logic               age_wrap, any_match, lk_miss, fill_take;
  logic [VPN_W-1:0]   lk_vpn;
  xent_t              sel;

  assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];

  xlate_match #(.NUM_ENT(NUM_ENT)) u_match (
    .ent     (ent_q),
    .vpn     (lk_vpn),
    .asn     (cur_asn),
    .match_v (match_v)
  );

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      valid_v[i] = ent_q[i].valid;
      acc_v[i]   = ent_q[i].accessed;
    end
  end

  xlate_victim #(.NUM_ENT(NUM_ENT)) u_victim (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .valid_v  (valid_v),
    .acc_v    (acc_v),
    .victim   (victim),
    .age_wrap (age_wrap)
  );

  // lookup path
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match_v[i]) hit_idx = IDX_W'(i);
    end
  end

  assign sel          = ent_q[hit_idx];
  assign any_match    = |match_v;
  assign lk_fault     = lk_valid && any_match && lk_user && !sel.user_ok;
  assign lk_hit       = lk_valid && any_match && !lk_fault;
  assign lk_miss      = lk_valid && !any_match;
  assign lk_paddr     = lk_hit ? {sel.ppn, lk_vaddr[OFS_W-1:0]} : '0;
  assign lk_dirty     = lk_hit && sel.dirty;
  assign lk_cacheable = lk_hit && sel.cacheable;

  assign refill_req = pend_q;
  assign refill_vpn = rvpn_q;
  assign refill_asn = rasn_q;

  assign fill_take = fill_valid && pend_q;
  assign ent_en    = lk_hit || fill_take || inval_valid || flush_all;
  assign pend_en   = fill_take || (lk_miss && !pend_q);

  // next state: hit housekeeping, fill, invalidate, flush (last wins)
  always_comb begin
    ent_d  = ent_q;
    pend_d = pend_q;
    rvpn_d = rvpn_q;
    rasn_d = rasn_q;
    if (lk_hit) begin
      ent_d[hit_idx].accessed = 1'b1;
      if (lk_write) ent_d[hit_idx].dirty = 1'b1;
    end
    if (fill_take) begin
      if (age_wrap) begin
        for (int i = 0; i < NUM_ENT; i++) ent_d[i].accessed = 1'b0;
      end
      ent_d[victim].valid     = 1'b1;
      ent_d[victim].glob      = fill_global;
      ent_d[victim].accessed  = 1'b0;
      ent_d[victim].dirty     = 1'b0;
      ent_d[victim].user_ok   = fill_user_ok;
      ent_d[victim].cacheable = fill_cacheable;
      ent_d[victim].asn       = rasn_q;
      ent_d[victim].vpn       = rvpn_q;
      ent_d[victim].ppn       = fill_ppn;
      pend_d                  = 1'b0;
    end else if (lk_miss && !pend_q) begin
      pend_d = 1'b1;
      rvpn_d = lk_vpn;
      rasn_d = cur_asn;
    end
    if (inval_valid) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (!ent_d[i].glob && (ent_d[i].asn == inval_asn)) ent_d[i].valid = 1'b0;
      end
    end
    if (flush_all) begin
      for (int i = 0; i < NUM_ENT; i++) ent_d[i].valid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
    end else if (ent_en) begin
      ent_q <= ent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q <= 1'b0;
      rvpn_q <= '0;
      rasn_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
      rvpn_q <= rvpn_d;
      rasn_q <= rasn_d;
    end
  end

  // R2
  match_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(match_v));

  // R5
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(lk_hit && lk_fault));

  // R3
  refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (refill_req && !fill_valid) |=> refill_req);

  // R3
  refill_tag_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (refill_req && !fill_valid) |=> ($stable(refill_vpn) && $stable(refill_asn)));

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush_all |=> (!lk_hit && !lk_fault));
endmodule

// File: tb/asn_xlate_buf_bench.sv
`timescale 1ns/1ps
module asn_xlate_buf_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_write, lk_user;
  logic [31:0] lk_vaddr;
  logic [7:0]  cur_asn;
  logic        lk_hit, lk_fault, lk_dirty, lk_cacheable;
  logic [31:0] lk_paddr;
  logic        refill_req;
  logic [19:0] refill_vpn;
  logic [7:0]  refill_asn;
  logic        fill_valid, fill_global, fill_user_ok, fill_cacheable;
  logic [19:0] fill_ppn;
  logic        flush_all, inval_valid;
  logic [7:0]  inval_asn;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          m_v [N], m_g [N], m_a [N], m_d [N], m_u [N], m_c [N];
  logic [7:0]  m_asn [N];
  logic [19:0] m_vpn [N], m_ppn [N];

  always #10 clk = ~clk;

  asn_xlate_buf u_asn_xlate_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_user(lk_user), .cur_asn(cur_asn),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .lk_dirty(lk_dirty), .lk_cacheable(lk_cacheable),
    .refill_req(refill_req), .refill_vpn(refill_vpn), .refill_asn(refill_asn),
    .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_global(fill_global),
    .fill_user_ok(fill_user_ok), .fill_cacheable(fill_cacheable),
    .flush_all(flush_all), .inval_valid(inval_valid), .inval_asn(inval_asn)
  );

  // page table held by the modelled walker
  function automatic bit pt_global(logic [19:0] vpn);
    return vpn[4:0] == 5'h1F;
  endfunction
  function automatic bit pt_user(logic [19:0] vpn);
    return vpn[2:0] != 3'b111;
  endfunction
  function automatic bit pt_cach(logic [19:0] vpn);
    return vpn[1];
  endfunction
  function automatic logic [19:0] pt_ppn(logic [19:0] vpn, logic [7:0] asn);
    return {vpn[11:0] ^ 12'h5A3, (pt_global(vpn) ? 8'h00 : asn)};
  endfunction

  function automatic int m_find(logic [19:0] vpn, logic [7:0] asn);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asn[i] == asn)) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (!m_a[i]) return i;
    return -1;
  endfunction

  task automatic m_install(logic [19:0] vpn, logic [7:0] asn);
    int v;
    v = m_victim();
    if (v < 0) begin
      for (int i = 0; i < N; i++) m_a[i] = 1'b0;
      v = 0;
    end
    m_v[v] = 1'b1; m_g[v] = pt_global(vpn); m_a[v] = 1'b0; m_d[v] = 1'b0;
    m_u[v] = pt_user(vpn); m_c[v] = pt_cach(vpn);
    m_asn[v] = asn; m_vpn[v] = vpn; m_ppn[v] = pt_ppn(vpn, asn);
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare the live lookup with the model; apply hit housekeeping
  task automatic check_now(string tag, output bit missed);
    int  idx;
    bit  e_fault, e_hit;
    idx     = m_find(lk_vaddr[31:12], cur_asn);
    e_fault = (idx >= 0) && lk_user && !m_u[idx];
    e_hit   = (idx >= 0) && !e_fault;
    chk(tag, "R2 hit", lk_hit, e_hit);
    chk(tag, "R5 fault", lk_fault, e_fault);
    chk(tag, "R2 paddr", lk_paddr, e_hit ? {m_ppn[idx], lk_vaddr[11:0]} : 32'h0);
    if (e_hit) begin
      chk(tag, "R6 dirty", lk_dirty, m_d[idx]);
      chk(tag, "R10 cacheable", lk_cacheable, m_c[idx]);
      m_a[idx] = 1'b1;
      if (lk_write) m_d[idx] = 1'b1;
    end
    missed = (idx < 0);
  endtask

  task automatic lookup(logic [31:0] va, bit wr, bit usr, logic [7:0] asn, string tag);
    bit missed;
    int w;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = usr; cur_asn = asn;
    #1;
    check_now(tag, missed);
    if (missed) begin
      w = 2 + int'($urandom % 6);
      for (int k = 0; k < w; k++) begin
        @(negedge clk); #1;
        chk("R3", "refill_req held", refill_req, 1);
      end
      chk("R3", "refill_vpn", refill_vpn, va[31:12]);
      chk("R3", "refill_asn", refill_asn, asn);
      @(negedge clk);
      fill_valid = 1'b1; fill_ppn = pt_ppn(va[31:12], asn);
      fill_global = pt_global(va[31:12]); fill_user_ok = pt_user(va[31:12]);
      fill_cacheable = pt_cach(va[31:12]);
      #1;
      chk("R3", "no hit in fill cycle", lk_hit, 0);
      m_install(va[31:12], asn);
      @(negedge clk);
      fill_valid = 1'b0;
      #1;
      chk("R3", "refill_req dropped", refill_req, 0);
      check_now(tag, missed);
    end
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1'b1;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    @(negedge clk);
    flush_all = 1'b0;
  endtask

  task automatic do_inval(logic [7:0] a);
    @(negedge clk);
    inval_valid = 1'b1; inval_asn = a;
    for (int i = 0; i < N; i++) if (!m_g[i] && m_asn[i] == a) m_v[i] = 1'b0;
    @(negedge clk);
    inval_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int r;
    r = int'($urandom(32'd4242));
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_write = 1'b0; lk_user = 1'b0;
    cur_asn = '0; fill_valid = 1'b0; fill_ppn = '0; fill_global = 1'b0;
    fill_user_ok = 1'b0; fill_cacheable = 1'b0; flush_all = 1'b0;
    inval_valid = 1'b0; inval_asn = '0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    #55 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "hit after reset", lk_hit, 0);
    chk("R1", "fault after reset", lk_fault, 0);
    chk("R1", "refill after reset", refill_req, 0);

    // first translation: miss, walk, then hit
    lookup(32'h0010_0ABC, 1'b0, 1'b0, 8'd1, "R1");
    lookup(32'h0010_0123, 1'b0, 1'b0, 8'd1, "R2");
    // same page, other task: separate entry
    lookup(32'h0010_0456, 1'b0, 1'b0, 8'd2, "R4");
    lookup(32'h0010_0456, 1'b0, 1'b0, 8'd1, "R4");
    // global page shared by all tasks
    lookup(32'h0001_F123, 1'b0, 1'b0, 8'd5, "R4");
    lookup(32'h0001_F777, 1'b0, 1'b0, 8'd9, "R4");
    // supervisor-only page
    lookup(32'h0010_7010, 1'b0, 1'b1, 8'd1, "R5");
    lookup(32'h0010_7010, 1'b0, 1'b0, 8'd1, "R5");
    // dirty on write
    lookup(32'h0010_0800, 1'b1, 1'b0, 8'd1, "R6");
    lookup(32'h0010_0804, 1'b0, 1'b0, 8'd1, "R6");
    lookup(32'h0010_2004, 1'b0, 1'b0, 8'd2, "R10");
    lookup(32'h0010_2004, 1'b0, 1'b0, 8'd2, "R10");
    // per-task invalidate
    do_inval(8'd1);
    lookup(32'h0010_0000, 1'b0, 1'b0, 8'd1, "R9");
    lookup(32'h0010_0000, 1'b0, 1'b0, 8'd2, "R9");
    lookup(32'h0001_F000, 1'b0, 1'b0, 8'd1, "R9");
    // full flush
    do_flush();
    lookup(32'h0001_F000, 1'b0, 1'b0, 8'd1, "R8");
    // replacement order
    do_flush();
    for (int i = 0; i < N; i++) lookup({20'h00300 + 20'(i), 12'h010}, 1'b0, 1'b0, 8'd1, "R7");
    lookup(32'h0031_0000, 1'b0, 1'b0, 8'd1, "R7");
    lookup(32'h0030_0000, 1'b0, 1'b0, 8'd1, "R7");
    lookup(32'h0030_1000, 1'b0, 1'b0, 8'd1, "R7");
    lookup(32'h0030_2000, 1'b0, 1'b0, 8'd1, "R7");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 100);
      if (op < 3) do_flush();
      else if (op < 8) do_inval(8'(1 + $urandom % 3));
      else lookup({20'h00200 + 20'($urandom % 32), 12'($urandom)},
                  1'($urandom), 1'($urandom), 8'(1 + $urandom % 3), "Rmix");
    end
    finish_run();
  end
endmodule